// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2-style DRAM from power-on to an operational state. After reset it waits for a power-stable indication. It then holds the clock-enable low for a long settling interval. After that it raises clock-enable and issues the fixed series of precharge, mode-register and refresh commands the memory expects. When the series is complete it waits for the delay-locked loop to lock and raises an init-done flag. The memory controller then takes over the command bus.

Every interval is a parameter counted in clock cycles, so a simulation can use short values while silicon uses the real ones. Each interval must be at least 2. The contents of the four mode registers come from input ports. The sequencer forces only the bits whose value it owns: the DLL-reset bit of the main register, and the DLL-enable bit and off-chip-driver calibration field of the extended register.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until `pwr_ok` is first sampled high, `cke` is 0, `cmd` is NOP and `init_done` is 0.
- R2: `cke` stays 0, with only NOP on `cmd`, for T_CKE_LOW cycles after the cycle in which `pwr_ok` is sampled high. It then rises and does not fall again before reset.
- R3: The first command is PRECHARGE-all. It comes T_CKE_HIGH cycles after `cke` rises, with `addr` = 14'h0400 (bit 10 high, all other bits 0) and `ba` = 0.
- R4: The commands come in this order: PRECHARGE-all; load ext2; load ext3; load ext; load main with DLL reset; PRECHARGE-all; N_REF REFRESH; load main; load ext with calibration default; load ext with calibration exit.
- R5: A mode load drives `ba` with the register it targets: 0 for main, 1 for ext, 2 for ext2, 3 for ext3. It drives `addr` with the matching config port, except for the bits named in R6 and R7. REFRESH drives `ba` = 0 and `addr` = 0.
- R6: The first main-register load forces `addr[8]` (DLL reset) to 1. The second forces it to 0.
- R7: Every ext-register load forces `addr[0]` to 0 (DLL enabled). `addr[9:7]` is 000 on the first load, 111 on the calibration-default load and 000 on the calibration-exit load.
- R8: Exactly N_REF REFRESH commands are issued, back to back, each followed by T_RFC cycles.
- R9: Each command is a single-cycle pulse, and only NOP appears between commands. The spacing to the next command is T_RP after a PRECHARGE, T_MRD after a mode load and T_RFC after a REFRESH.
- R10: `init_done` rises T_DLL cycles after the calibration-exit load. It then stays high with `cmd` at NOP until reset.
- R11: Once the sequence has started, `pwr_ok` has no effect, and the timing does not change if it falls.
- R12: `cmd` is {ras_n, cas_n, we_n} with chip select taken as active: 111 NOP, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_ok | input | 1 | Power and clock stable |
| mr_cfg | input | 14 | Main mode register value |
| emr_cfg | input | 14 | Extended mode register value |
| emr2_cfg | input | 14 | Extended register 2 value |
| emr3_cfg | input | 14 | Extended register 3 value |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Command {ras_n, cas_n, we_n} |
| ba | output | 3 | Bank address / register select |
| addr | output | 14 | Address / opcode bus |
| init_done | output | 1 | Initialization complete |

## Verification
A wrong step index appears on the command bus at the next issue slot. It shows as an out-of-order command, a wrong bank select or a wrong opcode value, so it is visible within one command interval. A corrupted wait counter shifts every later command by a fixed number of cycles. The bench therefore measures the spacing of each command against its predecessor rather than absolute times. A bad refresh repeat count shows up as a missing or extra REFRESH before the second main-register load. A state that skips ahead shows up as an early `cke` rise or an early `init_done`, measured from the `pwr_ok` cycle.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int T_CKE_LOW  = 10000,
  parameter int T_CKE_HIGH = 20,
  parameter int T_RP       = 4,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 26,
  parameter int T_DLL      = 200,
  parameter int N_REF      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_ok,
  input  logic [13:0] mr_cfg,
  input  logic [13:0] emr_cfg,
  input  logic [13:0] emr2_cfg,
  input  logic [13:0] emr3_cfg,
  output logic        cke,
  output logic [2:0]  cmd,
  output logic [2:0]  ba,
  output logic [13:0] addr,
  output logic        init_done
);

  localparam int M1   = (T_CKE_LOW > T_DLL) ? T_CKE_LOW : T_DLL;
  localparam int M2   = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int M3   = (M2 > T_CKE_HIGH) ? M2 : T_CKE_HIGH;
  localparam int M4   = (M3 > T_RP) ? M3 : T_RP;
  localparam int MAXW = (M4 > T_MRD) ? M4 : T_MRD;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int RW   = $clog2(N_REF + 1);

  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_LM  = 3'b000;

  localparam logic [3:0] STEP_REF  = 4'd6;
  localparam logic [3:0] STEP_LAST = 4'd9;

  localparam logic [13:0] DLL_RST  = 14'h0100;
  localparam logic [13:0] EXT_MASK = 14'h0381;
  localparam logic [13:0] OCD_DFLT = 14'h0380;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_ISSUE, ST_GAP, ST_LOCK, ST_DONE
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [3:0]    step;
  logic [RW-1:0] refs;

  logic [2:0]    s_cmd;
  logic [2:0]    s_ba;
  logic [13:0]   s_addr;
  logic [CW-1:0] s_wait;

  wire [13:0] ext_base = emr_cfg & ~EXT_MASK;

  always_comb begin
    s_cmd  = C_LM;
    s_ba   = 3'd0;
    s_addr = 14'h0000;
    s_wait = CW'(T_MRD);
    case (step)
      4'd0: begin s_cmd = C_PRE; s_addr = 14'h0400; s_wait = CW'(T_RP); end
      4'd1: begin s_ba = 3'd2; s_addr = emr2_cfg; end
      4'd2: begin s_ba = 3'd3; s_addr = emr3_cfg; end
      4'd3: begin s_ba = 3'd1; s_addr = ext_base; end
      4'd4: s_addr = mr_cfg | DLL_RST;
      4'd5: begin s_cmd = C_PRE; s_addr = 14'h0400; s_wait = CW'(T_RP); end
      4'd6: begin s_cmd = C_REF; s_wait = CW'(T_RFC); end
      4'd7: s_addr = mr_cfg & ~DLL_RST;
      4'd8: begin s_ba = 3'd1; s_addr = ext_base | OCD_DFLT; end
      4'd9: begin s_ba = 3'd1; s_addr = ext_base; s_wait = CW'(T_DLL); end
      default: s_cmd = C_NOP;
    endcase
  end

  wire issuing = (state == ST_ISSUE);
  wire expired = (cnt <= CW'(1));

  assign cke       = !(state == ST_IDLE || state == ST_LOW);
  assign cmd       = issuing ? s_cmd  : C_NOP;
  assign ba        = issuing ? s_ba   : 3'd0;
  assign addr      = issuing ? s_addr : 14'h0000;
  assign init_done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      step  <= 4'd0;
      refs  <= RW'(N_REF);
    end else begin
      case (state)
        ST_IDLE:
          if (pwr_ok) begin
            state <= ST_LOW;
            cnt   <= CW'(T_CKE_LOW);
          end
        ST_LOW:
          if (expired) begin
            state <= ST_HIGH;
            cnt   <= CW'(T_CKE_HIGH);
          end else cnt <= cnt - 1'b1;
        ST_HIGH:
          if (expired) state <= ST_ISSUE;
          else cnt <= cnt - 1'b1;
        ST_ISSUE: begin
          cnt   <= s_wait - 1'b1;
          state <= (step == STEP_LAST) ? ST_LOCK : ST_GAP;
        end
        ST_GAP:
          if (expired) begin
            state <= ST_ISSUE;
            if (step == STEP_REF && refs > RW'(1)) refs <= refs - 1'b1;
            else step <= step + 4'd1;
          end else cnt <= cnt - 1'b1;
        ST_LOCK:
          if (expired) state <= ST_DONE;
          else cnt <= cnt - 1'b1;
        default: state <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic [2:0]  cmd,
  input logic [2:0]  ba,
  input logic [13:0] addr,
  input logic        init_done
);

  AST_CKE_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cke)); // R2

  AST_NOP_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd == 3'b111); // R2

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b010 |-> addr == 14'h0400 && ba == 3'd0); // R3

  AST_REF_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b001 |-> addr == 14'h0000 && ba == 3'd0); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 3'b111 |=> cmd == 3'b111); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cmd == 3'b111 && cke); // R10

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b111 || cmd == 3'b010 || cmd == 3'b001 || cmd == 3'b000); // R12

endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd),
  .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;

  localparam int CKL = 20, CKH = 5, RP = 3, MRD = 2, RFC = 7, DLL = 12, NREF = 2;
  localparam int NCMD = 11;

  localparam logic [27:0] EXP [NCMD] = '{
    {3'b010, 3'd0, 14'h0400, 8'(RP)},
    {3'b000, 3'd2, 14'h0080, 8'(MRD)},
    {3'b000, 3'd3, 14'h0000, 8'(MRD)},
    {3'b000, 3'd1, 14'h0004, 8'(MRD)},
    {3'b000, 3'd0, 14'h0343, 8'(MRD)},
    {3'b010, 3'd0, 14'h0400, 8'(RP)},
    {3'b001, 3'd0, 14'h0000, 8'(RFC)},
    {3'b001, 3'd0, 14'h0000, 8'(RFC)},
    {3'b000, 3'd0, 14'h0243, 8'(MRD)},
    {3'b000, 3'd1, 14'h0384, 8'(MRD)},
    {3'b000, 3'd1, 14'h0004, 8'(DLL)}
  };

  logic clk = 0, rst_n = 0, pwr_ok = 0;
  logic cke, init_done;
  logic [2:0] cmd, ba;
  logic [13:0] addr;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ddr_init_seq #(
    .T_CKE_LOW(CKL), .T_CKE_HIGH(CKH), .T_RP(RP), .T_MRD(MRD),
    .T_RFC(RFC), .T_DLL(DLL), .N_REF(NREF)
  ) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .mr_cfg(14'h0343), .emr_cfg(14'h0385), .emr2_cfg(14'h0080), .emr3_cfg(14'h0000),
    .cke(cke), .cmd(cmd), .ba(ba), .addr(addr), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int vi = 0, rise = -1, last = -1, done_at = -1, bad_low = 0, bad_done = 0;
    repeat (3) @(negedge clk);
    chk(cke == 0 && cmd == 3'b111 && init_done == 0, "R1 in reset", {cke, cmd, init_done}, 5'b01110);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    chk(cke == 0 && cmd == 3'b111 && init_done == 0, "R1 waiting pwr_ok", {cke, cmd, init_done}, 5'b01110);

    pwr_ok = 1;
    for (int cyc = 1; cyc <= 150; cyc++) begin
      @(negedge clk);
      if (cyc == 3) pwr_ok = 0; // R11: dropping pwr_ok must not disturb the run
      if (!cke && cmd != 3'b111) bad_low++;
      if (cke && rise < 0) rise = cyc;
      if (init_done && done_at < 0) done_at = cyc;
      if (done_at >= 0 && (!init_done || cmd != 3'b111)) bad_done++;
      if (cmd != 3'b111) begin
        if (vi >= NCMD) chk(0, "R4 extra command", cmd, 3'b111);
        else begin
          chk(cmd == EXP[vi][27:25], "R4/R12 command code", cmd, EXP[vi][27:25]);
          chk(ba == EXP[vi][24:22], "R5 bank select", ba, EXP[vi][24:22]);
          chk(addr == EXP[vi][21:8], "R5 R6 R7 opcode", addr, EXP[vi][21:8]);
          if (vi == 0) chk(cyc - rise == CKH, "R3 first precharge delay", cyc - rise, CKH);
          else chk(cyc - last == int'(EXP[vi-1][7:0]), "R8 R9 spacing", cyc - last, EXP[vi-1][7:0]);
        end
        last = cyc;
        vi++;
      end
    end
    chk(rise == CKL + 1, "R2 R11 cke low interval", rise, CKL + 1);
    chk(bad_low == 0, "R2 command while cke low", bad_low, 0);
    chk(vi == NCMD, "R4 R8 command count", vi, NCMD);
    chk(done_at - last == DLL, "R10 done delay", done_at - last, DLL);
    chk(bad_done == 0, "R10 done sticky and quiet", bad_done, 0);

    @(negedge clk) rst_n = 0;
    @(negedge clk);
    chk(cke == 0 && cmd == 3'b111 && init_done == 0, "R1 reset after done", {cke, cmd, init_done}, 5'b01110);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(cke == 0 && init_done == 0, "R1 R11 no start without pwr_ok", {cke, init_done}, 0);
    summary();
  end

endmodule